// File: doc/BRIEF.md
# Multiplexed Bus Target Handshake Engine

This block is the responding side of a parallel bus on which address and data share one 32-bit path. When the initiator pulls its frame line low, the block captures the address and command in that first cycle. It then decides whether the address falls inside its programmed window. If it does, the block answers with a device-select strobe after a chosen latency: one, two or three cycles after the address cycle. A small word-wide store sits behind the bus.

Each data phase completes on the clock edge where the initiator-ready and target-ready lines are both low. A per-phase wait count can delay target-ready, so wait states can be inserted deliberately. Burst transfers step through consecutive words and wrap at the end of the store. Write lanes are qualified by active-low byte enables. When the last phase completes, the block drives its control lines high for one cycle and then releases them.

Top module: `bus_tgt_engine`

## Requirements
- R1: The address and command are captured at the clock edge that ends the first cycle with frame_ni low. Command code 4'b0110 (read) and 4'b0111 (write) are claimed when base_i <= ad_i <= limit_i. The start word is ((ad_i - base_i) >> 2) mod DEPTH, so ad_i[1:0] has no effect.
- R2: devsel_no goes low speed_i+1 cycles after the address cycle: 0 means 1 cycle, 1 means 2 cycles, and 2 or 3 mean 3 cycles. It stays low through the last data phase.
- R3: A word moves only on an edge where irdy_ni and trdy_no are both low. The word index then advances by one and wraps modulo DEPTH.
- R4: Once trdy_no is low, trdy_no, devsel_no and, on reads, ad_o stay unchanged until the phase completes.
- R5: On a read, ad_oe_o is high in every cycle in which trdy_no is low, and ad_o then carries the addressed word. The block never drives AD in the cycle right after the address cycle.
- R6: After the phase that completes with frame_ni high, the block spends one cycle with ctl_oe_o high and devsel_no and trdy_no both high. In the following cycle ctl_oe_o is low.
- R7: With wait_i = 0 and the initiator always ready, a burst write moves one word on every clock.
- R8: On a write, byte lane b (ad_i[8b+7:8b]) is stored only when cbe_ni[b] is 0. The other lanes keep their value.
- R9: A command other than the two claimed codes, or an address outside the window, leaves devsel_no and trdy_no high and ctl_oe_o and ad_oe_o low, and leaves the store unchanged.
- R10: In each data phase, trdy_no goes low wait_i cycles after the phase starts. A phase starts either in the first cycle after device select or in the cycle after the previous transfer. For a fast-latency read, the first phase waits at least one cycle.
- R11: After reset, all handshake outputs are released, ctl_oe_o and ad_oe_o are low, and every stored word reads as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ad_i | input | 32 | Shared address/data path as seen by the target |
| ad_o | output | 32 | Read data driven toward the shared path |
| ad_oe_o | output | 1 | Output enable for ad_o |
| cbe_ni | input | 4 | Command in the address cycle, active-low byte enables in data phases |
| frame_ni | input | 1 | Initiator frame, active low |
| irdy_ni | input | 1 | Initiator ready, active low |
| trdy_no | output | 1 | Target ready, active low |
| devsel_no | output | 1 | Device select, active low |
| ctl_oe_o | output | 1 | Output enable for trdy_no and devsel_no |
| base_i | input | 32 | Lowest claimed byte address |
| limit_i | input | 32 | Highest claimed byte address |
| speed_i | input | 2 | Device-select latency choice |
| wait_i | input | 4 | Wait cycles inserted per data phase |

## Verification
The two functions that can fall in the same cycle are the initiator's ready and the end of the target's wait count. If they coincide, the phase completes on that edge. If the initiator arrives first, it waits. If the target arrives first, it must hold its ready line and data. The bench sweeps every latency choice against several wait counts and initiator delays. Because the expected devsel_no, trdy_no and enable levels are computed arithmetically for every cycle, both orderings and the coincident case are judged cycle by cycle, and the data returned on each completing edge is compared with a reference store.

// File: rtl/bus_tgt_pkg.sv
`timescale 1ns/1ps
package bus_tgt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_LAT,
    ST_DATA,
    ST_TURN,
    ST_SKIP
  } tgt_st_e;

  localparam logic [3:0] CMD_MEM_RD = 4'b0110;
  localparam logic [3:0] CMD_MEM_WR = 4'b0111;
endpackage

// File: rtl/bus_tgt_decode.sv
`timescale 1ns/1ps
module bus_tgt_decode
  import bus_tgt_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int IDX_W  = 4
) (
  input  logic [ADDR_W-1:0] ad_i,
  input  logic [3:0]        cmd_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] limit_i,
  output logic              hit_o,
  output logic              wr_o,
  output logic [IDX_W-1:0]  idx_o
);
  logic cmd_ok, in_win;

  always_comb begin
    cmd_ok = (cmd_i == CMD_MEM_RD) || (cmd_i == CMD_MEM_WR);
    in_win = (ad_i >= base_i) && (ad_i <= limit_i);
    hit_o  = cmd_ok && in_win;
    wr_o   = (cmd_i == CMD_MEM_WR);
    idx_o  = IDX_W'((ad_i - base_i) >> 2);
  end
endmodule

// File: rtl/bus_tgt_mem.sv
`timescale 1ns/1ps
module bus_tgt_mem #(
  parameter int DEPTH  = 16,
  parameter int DATA_W = 32,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int NB    = DATA_W / 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [NB-1:0]     be_ni,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o
);
  for (genvar b = 0; b < NB; b++) begin : g_lane
    logic [7:0] lane_q [DEPTH];

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int w = 0; w < DEPTH; w++) lane_q[w] <= 8'h00;
      end else if (we_i && !be_ni[b]) begin
        lane_q[idx_i] <= wdata_i[b*8 +: 8];
      end
    end

    assign rdata_o[b*8 +: 8] = lane_q[idx_i];
  end
endmodule

// File: rtl/bus_tgt_ctrl.sv
`timescale 1ns/1ps
module bus_tgt_ctrl
  import bus_tgt_pkg::*;
#(
  parameter int IDX_W  = 4,
  parameter int WAIT_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              frame_ni,
  input  logic              irdy_ni,
  input  logic              hit_i,
  input  logic              wr_i,
  input  logic [IDX_W-1:0]  idx_i,
  input  logic [1:0]        speed_i,
  input  logic [WAIT_W-1:0] wait_i,
  output logic              devsel_no,
  output logic              trdy_no,
  output logic              ctl_oe_o,
  output logic              ad_oe_o,
  output logic [IDX_W-1:0]  idx_o,
  output logic              we_o
);
  tgt_st_e           st_q;
  logic              lat_q;
  logic              fresh_q;
  logic              wr_q;
  logic [IDX_W-1:0]  idx_q;
  logic [WAIT_W-1:0] wcnt_q;
  logic [1:0]        spd_q;
  logic [1:0]        age_q;
  logic              trdy_act, xfer;

  // fresh_q marks the first data cycle after a fast claim: AD still turning around
  assign trdy_act = (wcnt_q == '0) && (wr_q || !fresh_q);
  assign xfer     = (st_q == ST_DATA) && trdy_act && !irdy_ni;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q    <= ST_IDLE;
      lat_q   <= 1'b0;
      fresh_q <= 1'b0;
      wr_q    <= 1'b0;
      idx_q   <= '0;
      wcnt_q  <= '0;
      spd_q   <= 2'd0;
    end else begin
      unique case (st_q)
        ST_IDLE: begin
          if (!frame_ni) begin
            wr_q   <= wr_i;
            idx_q  <= idx_i;
            wcnt_q <= wait_i;
            spd_q  <= (speed_i == 2'd3) ? 2'd2 : speed_i;
            if (!hit_i) begin
              st_q <= ST_SKIP;
            end else if (speed_i == 2'd0) begin
              st_q    <= ST_DATA;
              fresh_q <= 1'b1;
            end else begin
              st_q  <= ST_LAT;
              lat_q <= (speed_i != 2'd1);
            end
          end
        end
        ST_LAT: begin
          if (lat_q) lat_q <= 1'b0;
          else begin
            st_q    <= ST_DATA;
            fresh_q <= 1'b0;
          end
        end
        ST_DATA: begin
          fresh_q <= 1'b0;
          if (xfer) begin
            idx_q  <= idx_q + 1'b1;
            wcnt_q <= wait_i;
            if (frame_ni) st_q <= ST_TURN;
          end else if (wcnt_q != '0) begin
            wcnt_q <= wcnt_q - 1'b1;
          end
        end
        ST_TURN: st_q <= ST_IDLE;
        ST_SKIP: if (frame_ni && irdy_ni) st_q <= ST_IDLE;
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign devsel_no = (st_q != ST_DATA);
  assign trdy_no   = !((st_q == ST_DATA) && trdy_act);
  assign ctl_oe_o  = (st_q == ST_DATA) || (st_q == ST_TURN);
  assign ad_oe_o   = (st_q == ST_DATA) && !wr_q && !fresh_q;
  assign idx_o     = idx_q;
  assign we_o      = xfer && wr_q;

  // cycles since the address cycle, saturating at 3
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) age_q <= 2'd0;
    else if (st_q == ST_IDLE) age_q <= frame_ni ? 2'd0 : 2'd1;
    else if (age_q != 2'd0 && age_q != 2'd3) age_q <= age_q + 2'd1;
  end

  p_devsel_lat_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(devsel_no) |-> (age_q == spd_q + 2'd1));

  p_trdy_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trdy_no && irdy_ni) |=> (!trdy_no && !devsel_no));

  p_rd_drive_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trdy_no && !wr_q) |-> ad_oe_o);

  p_release_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(ctl_oe_o) |-> ($past(trdy_no) && $past(devsel_no)));

  p_miss_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q == ST_SKIP) |-> (devsel_no && trdy_no && !ctl_oe_o && !we_o));
endmodule

// File: rtl/bus_tgt_engine.sv
`timescale 1ns/1ps
module bus_tgt_engine #(
  parameter int DEPTH  = 16,
  parameter int WAIT_W = 4,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [31:0]       ad_i,
  output logic [31:0]       ad_o,
  output logic              ad_oe_o,
  input  logic [3:0]        cbe_ni,
  input  logic              frame_ni,
  input  logic              irdy_ni,
  output logic              trdy_no,
  output logic              devsel_no,
  output logic              ctl_oe_o,
  input  logic [31:0]       base_i,
  input  logic [31:0]       limit_i,
  input  logic [1:0]        speed_i,
  input  logic [WAIT_W-1:0] wait_i
);
  logic             dec_hit, dec_wr;
  logic [IDX_W-1:0] dec_idx, cur_idx;
  logic             mem_we;

  bus_tgt_decode #(.ADDR_W(32), .IDX_W(IDX_W)) u_decode (
    .ad_i    (ad_i),
    .cmd_i   (cbe_ni),
    .base_i  (base_i),
    .limit_i (limit_i),
    .hit_o   (dec_hit),
    .wr_o    (dec_wr),
    .idx_o   (dec_idx)
  );

  bus_tgt_ctrl #(.IDX_W(IDX_W), .WAIT_W(WAIT_W)) u_ctrl (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .frame_ni  (frame_ni),
    .irdy_ni   (irdy_ni),
    .hit_i     (dec_hit),
    .wr_i      (dec_wr),
    .idx_i     (dec_idx),
    .speed_i   (speed_i),
    .wait_i    (wait_i),
    .devsel_no (devsel_no),
    .trdy_no   (trdy_no),
    .ctl_oe_o  (ctl_oe_o),
    .ad_oe_o   (ad_oe_o),
    .idx_o     (cur_idx),
    .we_o      (mem_we)
  );

  bus_tgt_mem #(.DEPTH(DEPTH), .DATA_W(32)) u_mem (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .we_i    (mem_we),
    .be_ni   (cbe_ni),
    .idx_i   (cur_idx),
    .wdata_i (ad_i),
    .rdata_o (ad_o)
  );

  p_we_both_rdy_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_we |-> (!irdy_ni && !trdy_no));

  p_rdata_stable_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!trdy_no && irdy_ni && ad_oe_o) |=> $stable(ad_o));
endmodule

// File: tb/bus_tgt_engine_test.sv
`timescale 1ns/1ps
module bus_tgt_engine_test;
  localparam int DEPTH = 16;
  localparam int WAIT_W = 4;
  localparam logic [31:0] BASE = 32'h0000_1000;
  localparam logic [31:0] LIMIT = 32'h0000_103F;
  localparam int WD_CYC = 150000;

  logic clk_i = 1'b0;
  logic rst_ni;
  logic [31:0] ad_i, ad_o;
  logic ad_oe_o;
  logic [3:0] cbe_ni;
  logic frame_ni, irdy_ni, trdy_no, devsel_no, ctl_oe_o;
  logic [31:0] base_i, limit_i;
  logic [1:0] speed_i;
  logic [WAIT_W-1:0] wait_i;

  int n_chk = 0;
  int n_err = 0;
  int seed = 1;
  logic [31:0] ref_mem [DEPTH];

  always #2.5 clk_i = ~clk_i;

  bus_tgt_engine #(.DEPTH(DEPTH), .WAIT_W(WAIT_W)) uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .ad_i(ad_i), .ad_o(ad_o), .ad_oe_o(ad_oe_o),
    .cbe_ni(cbe_ni), .frame_ni(frame_ni), .irdy_ni(irdy_ni), .trdy_no(trdy_no),
    .devsel_no(devsel_no), .ctl_oe_o(ctl_oe_o), .base_i(base_i), .limit_i(limit_i),
    .speed_i(speed_i), .wait_i(wait_i)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_txn(input bit wr, input logic [31:0] addr, input int n, input int spd,
                         input int wt, input int idly, input logic [3:0] be, input string tag);
    int k, ph, c, ic, lat, thr, first_x, last_x, base_idx, idx;
    bit ind, xf;
    logic [3:0] exp_v, act_v;
    logic [31:0] wd;
    speed_i = 2'(spd);
    wait_i = WAIT_W'(wt);
    frame_ni = 1'b0;
    irdy_ni = 1'b1;
    ad_i = addr;
    cbe_ni = wr ? 4'b0111 : 4'b0110;
    base_idx = int'((addr - BASE) >> 2) % DEPTH;
    lat = (spd > 2) ? 3 : spd + 1;
    ph = 0; c = 0; ic = 0; k = 0; first_x = -1; last_x = -1;
    while (ph < n && k < 200) begin
      @(negedge clk_i);
      k++;
      irdy_ni = !(ic >= idly);
      frame_ni = (ph == n - 1) && !irdy_ni;
      idx = (base_idx + ph) % DEPTH;
      wd = {addr[15:0] ^ 16'(ph * 37), 16'(seed)};
      seed++;
      ad_i = wr ? wd : 32'h0;
      cbe_ni = be;
      ind = (k >= lat);
      thr = (ph == 0 && spd == 0 && !wr && wt < 1) ? 1 : wt;
      exp_v = {!ind, !(ind && c >= thr), ind, ind && !wr && !(spd == 0 && k == 1)};
      act_v = {devsel_no, trdy_no, ctl_oe_o, ad_oe_o};
      // R2 R4 R5 R10: per-cycle handshake levels
      chk(act_v === exp_v, "R2 R4 R5 R10 handshake", 32'(act_v), 32'(exp_v));
      xf = !irdy_ni && !trdy_no;
      if (xf) begin
        if (!wr) chk(ad_o === ref_mem[idx], tag, ad_o, ref_mem[idx]);
        else
          for (int b = 0; b < 4; b++)
            if (!be[b]) ref_mem[idx][b*8 +: 8] = wd[b*8 +: 8];
        if (first_x < 0) first_x = k;
        last_x = k;
        ph++; c = 0; ic = 0;
      end else begin
        if (ind) c++;
        ic++;
      end
    end
    if (ph < n) chk(1'b0, "R3 phase never completed", 32'(ph), 32'(n));
    if (wt == 0 && idly == 0 && n > 1)
      chk(last_x - first_x == n - 1, "R7 one word per clock", 32'(last_x - first_x), 32'(n - 1));
    @(negedge clk_i);
    frame_ni = 1'b1; irdy_ni = 1'b1; ad_i = 32'h0; cbe_ni = 4'hF;
    chk({devsel_no, trdy_no, ctl_oe_o, ad_oe_o} === 4'b1110, "R6 drive high before release",
        32'({devsel_no, trdy_no, ctl_oe_o, ad_oe_o}), 32'h000E);
    @(negedge clk_i);
    chk({devsel_no, trdy_no, ctl_oe_o, ad_oe_o} === 4'b1100, "R6 lines released",
        32'({devsel_no, trdy_no, ctl_oe_o, ad_oe_o}), 32'h000C);
  endtask

  task automatic run_miss(input logic [31:0] addr, input logic [3:0] cmd);
    frame_ni = 1'b0; irdy_ni = 1'b1; ad_i = addr; cbe_ni = cmd;
    speed_i = 2'd0; wait_i = '0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk_i);
      frame_ni = 1'b1; irdy_ni = 1'b0; ad_i = 32'hDEAD_BEEF; cbe_ni = 4'h0;
      chk({devsel_no, trdy_no, ctl_oe_o, ad_oe_o} === 4'b1100, "R9 unclaimed stays quiet",
          32'({devsel_no, trdy_no, ctl_oe_o, ad_oe_o}), 32'h000C);
    end
    @(negedge clk_i);
    irdy_ni = 1'b1; ad_i = 32'h0; cbe_ni = 4'hF;
    @(negedge clk_i);
    chk({devsel_no, trdy_no, ctl_oe_o, ad_oe_o} === 4'b1100, "R9 idle after abort",
        32'({devsel_no, trdy_no, ctl_oe_o, ad_oe_o}), 32'h000C);
  endtask

  initial begin
    #(WD_CYC * 5);
    n_err++;
    $display("FAIL R3 watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < DEPTH; i++) ref_mem[i] = 32'h0;
    rst_ni = 1'b0; frame_ni = 1'b1; irdy_ni = 1'b1; ad_i = 32'h0; cbe_ni = 4'hF;
    base_i = BASE; limit_i = LIMIT; speed_i = 2'd0; wait_i = '0;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk({devsel_no, trdy_no, ctl_oe_o, ad_oe_o} === 4'b1100, "R11 reset outputs",
        32'({devsel_no, trdy_no, ctl_oe_o, ad_oe_o}), 32'h000C);
    // R11: whole store reads zero
    run_txn(1'b0, BASE, DEPTH, 1, 0, 0, 4'h0, "R11 zero after reset");

    // R2 R10 R3: sweep latency, wait count and initiator delay
    for (int s = 0; s < 3; s++)
      for (int w = 0; w < 3; w++)
        for (int d = 0; d < 2; d++) begin
          logic [31:0] a;
          a = BASE + 32'(((s * 9 + w * 3 + d) % DEPTH) * 4);
          run_txn(1'b1, a, 3, s, w, d, 4'h0, "R3 write");
          run_txn(1'b0, a, 3, s, w, d, 4'h0, "R3 read back");
        end

    // R3: burst wraps modulo DEPTH
    run_txn(1'b1, BASE + 32'(14 * 4), 4, 1, 0, 0, 4'h0, "R3 wrap write");
    run_txn(1'b0, BASE + 32'(14 * 4), 4, 2, 1, 0, 4'h0, "R3 wrap read");

    // R8: every byte-enable pattern
    for (int be = 0; be < 16; be++) begin
      run_txn(1'b1, BASE + 32'h14, 1, be % 3, 0, be % 2, 4'(be), "R8 lane write");
      run_txn(1'b0, BASE + 32'h14, 1, 1, 0, 0, 4'h0, "R8 lane merge");
    end

    // R7: full-rate bursts, slow read latency paired with fast read
    run_txn(1'b1, BASE + 32'h20, 6, 0, 0, 0, 4'h0, "R7 burst write");
    run_txn(1'b0, BASE + 32'h20, 6, 0, 0, 0, 4'h0, "R7 burst read");
    run_txn(1'b0, BASE + 32'h20, 6, 3, 2, 1, 4'h0, "R2 slow alias read");

    // R1: window edges and ignored low address bits
    run_txn(1'b0, LIMIT - 32'h3, 1, 0, 1, 0, 4'h0, "R1 top word");
    run_txn(1'b0, BASE + 32'h7, 2, 1, 0, 1, 4'h0, "R1 low bits ignored");

    // R9: misses, then store unchanged
    run_miss(BASE - 32'h4, 4'b0111);
    run_miss(LIMIT + 32'h1, 4'b0110);
    run_miss(BASE + 32'h8, 4'b0011);
    run_txn(1'b0, BASE, DEPTH, 2, 0, 0, 4'h0, "R9 store unchanged");

    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule